// File: doc/BRIEF.md
# Early Transmit Auto-Start Trigger

This block decides when a transmit engine may begin sending a packet that the host has already put in the transmit queue while its payload is still being copied into the packet buffer. It counts the bytes written into the currently selected transmit buffer. It compares that count with a programmable threshold, given in units of 16 bytes. It raises a one-cycle start pulse once the enqueued packet has enough data in place.

Automatic starting is in force only when the host has enabled auto-start and early transmit, the receive-side selection bit is clear, and the threshold is non-zero. In any other configuration the block forwards the host's manual start request and ignores enqueue events. Selecting a new packet clears the byte count and cancels any pending automatic start.

Top module: `etx_auto_start`

## Requirements
- R1: The byte count is 0 after reset and is cleared in the cycle `pkt_sel_i` is high. Otherwise, when `wr_valid_i` is high, the count grows by `wr_bytes_i` (0 to 3 bytes per write). The count saturates at 2047 and does not wrap.
- R2: Auto mode is active only when `auto_tx_i`=1, `early_tx_en_i`=1, `rcv_sel_i`=0 and `thresh_i`!=0. If any one of these conditions fails, the block is in manual mode.
- R3: The threshold counts as met when the registered byte count is at least `thresh_i`*16. A byte write made in the same cycle does not take part in that cycle's comparison.
- R4: If `enq_i` arrives in auto mode before the threshold is met, the block arms. `tx_start_o` then goes high in the cycle after the first cycle in which the block is armed and the threshold is met.
- R5: If the threshold is already met in the cycle `enq_i` is high in auto mode, `tx_start_o` goes high in the next cycle.
- R6: In auto mode each `tx_start_o` pulse is one cycle wide. At most one pulse is produced per enqueue, and none follows until the next `enq_i`.
- R7: In manual mode `tx_start_o` equals `manual_start_i` delayed by one cycle, and `enq_i` has no effect. In auto mode `manual_start_i` has no effect.
- R8: A threshold value of 0 turns the automatic function off, so the block forwards the manual request.
- R9: A pending automatic start is cancelled by `pkt_sel_i`, or by leaving auto mode. A cancelled start does not fire later, even when the threshold is reached or auto mode returns.
- R10: A threshold of 128 or more is never met, because the count saturates below 2048.
- R11: After reset `tx_start_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| thresh_i | input | 8 | Start threshold in 16-byte units; 0 disables auto start |
| auto_tx_i | input | 1 | Auto-start enable |
| early_tx_en_i | input | 1 | Early transmit enable |
| rcv_sel_i | input | 1 | Receive-side packet selection; must be 0 for auto start |
| pkt_sel_i | input | 1 | New packet selected; clears the byte count |
| wr_valid_i | input | 1 | Byte write into the selected buffer |
| wr_bytes_i | input | 2 | Bytes in this write |
| enq_i | input | 1 | Packet enqueued for transmit |
| manual_start_i | input | 1 | Host start request used in manual mode |
| tx_start_o | output | 1 | Transmit start pulse |

## Verification
The trigger is driven with enqueues that come before the threshold and with enqueues that come after it. These two cases separate arming (R4) from firing at once (R5), and the same-cycle write pattern shows that the comparison uses the registered count. Each of the four mode-gating inputs is toggled on its own, together with manual requests and spare enqueues, to show which input path reaches the output. Cancellation by packet selection or by a mode drop is followed by writes past the threshold to show that nothing fires late. Long write bursts that run past 2047 then tell saturation apart from wrap-around through thresholds 127 and 128.

// File: rtl/etx_pkg.sv
package etx_pkg;
  localparam int unsigned THR_W      = 8;
  localparam int unsigned CNT_W      = 11;
  localparam int unsigned WR_W       = 2;
  localparam int unsigned UNIT_SHIFT = 4;

  typedef enum logic {
    ARM_IDLE = 1'b0,
    ARM_WAIT = 1'b1
  } arm_state_e;
endpackage

// File: rtl/etx_byte_counter.sv
module etx_byte_counter #(
  parameter int unsigned CNT_W = 11,
  parameter int unsigned WR_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             add_i,
  input  logic [WR_W-1:0]  add_bytes_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   sum;

  assign sum = {1'b0, cnt_q} + {{(CNT_W+1-WR_W){1'b0}}, add_bytes_i};

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (add_i) cnt_d = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/etx_threshold_cmp.sv
module etx_threshold_cmp #(
  parameter int unsigned THR_W      = 8,
  parameter int unsigned CNT_W      = 11,
  parameter int unsigned UNIT_SHIFT = 4
) (
  input  logic [THR_W-1:0] thresh_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             auto_tx_i,
  input  logic             early_tx_en_i,
  input  logic             rcv_sel_i,
  output logic             auto_en_o,
  output logic             met_o
);
  localparam int unsigned LIM_W = THR_W + UNIT_SHIFT;
  localparam int unsigned CMP_W = (LIM_W > CNT_W) ? LIM_W : CNT_W;

  logic [CMP_W-1:0] limit;
  logic [CMP_W-1:0] cnt_ext;

  assign limit   = {{(CMP_W-LIM_W){1'b0}}, thresh_i, {UNIT_SHIFT{1'b0}}};
  assign cnt_ext = {{(CMP_W-CNT_W){1'b0}}, cnt_i};

  assign auto_en_o = auto_tx_i & early_tx_en_i & ~rcv_sel_i & (|thresh_i);
  assign met_o     = (cnt_ext >= limit);
endmodule

// File: rtl/etx_start_ctrl.sv
module etx_start_ctrl
  import etx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic auto_en_i,
  input  logic met_i,
  input  logic enq_i,
  input  logic sel_i,
  input  logic manual_i,
  output logic start_o,
  output logic armed_o
);
  arm_state_e state_q, state_d;
  logic       fire;
  logic       start_q, start_d;

  // pending request: this cycle's enqueue or an earlier armed one
  assign fire = auto_en_i & ~sel_i & met_i & (enq_i | (state_q == ARM_WAIT));

  always_comb begin
    state_d = ARM_IDLE;
    if (auto_en_i && !sel_i && !met_i && (enq_i || state_q == ARM_WAIT))
      state_d = ARM_WAIT;
    start_d = auto_en_i ? fire : manual_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ARM_IDLE;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
    end
  end

  assign start_o = start_q;
  assign armed_o = (state_q == ARM_WAIT);
endmodule

// File: rtl/etx_auto_start.sv
module etx_auto_start
  import etx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [THR_W-1:0] thresh_i,
  input  logic             auto_tx_i,
  input  logic             early_tx_en_i,
  input  logic             rcv_sel_i,
  input  logic             pkt_sel_i,
  input  logic             wr_valid_i,
  input  logic [WR_W-1:0]  wr_bytes_i,
  input  logic             enq_i,
  input  logic             manual_start_i,
  output logic             tx_start_o
);
  logic [CNT_W-1:0] cnt_w;
  logic             auto_en_w;
  logic             met_w;
  logic             armed_w;

  etx_byte_counter #(
    .CNT_W(CNT_W),
    .WR_W (WR_W)
  ) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (pkt_sel_i),
    .add_i      (wr_valid_i),
    .add_bytes_i(wr_bytes_i),
    .cnt_o      (cnt_w)
  );

  etx_threshold_cmp #(
    .THR_W     (THR_W),
    .CNT_W     (CNT_W),
    .UNIT_SHIFT(UNIT_SHIFT)
  ) i_cmp (
    .thresh_i     (thresh_i),
    .cnt_i        (cnt_w),
    .auto_tx_i    (auto_tx_i),
    .early_tx_en_i(early_tx_en_i),
    .rcv_sel_i    (rcv_sel_i),
    .auto_en_o    (auto_en_w),
    .met_o        (met_w)
  );

  etx_start_ctrl i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .auto_en_i(auto_en_w),
    .met_i    (met_w),
    .enq_i    (enq_i),
    .sel_i    (pkt_sel_i),
    .manual_i (manual_start_i),
    .start_o  (tx_start_o),
    .armed_o  (armed_w)
  );
endmodule

// File: rtl/etx_auto_start_chk.sv
module etx_auto_start_chk
  import etx_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pkt_sel_i,
  input logic             enq_i,
  input logic             manual_start_i,
  input logic [THR_W-1:0] thresh_i,
  input logic             tx_start_o,
  input logic [CNT_W-1:0] cnt_i,
  input logic             auto_en_i,
  input logic             met_i,
  input logic             armed_i
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  assert_clear_on_select_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_sel_i |=> (cnt_i == '0));

  assert_no_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == CNT_MAX && !pkt_sel_i) |=> (cnt_i == CNT_MAX));

  assert_manual_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_en_i |=> (tx_start_o == $past(manual_start_i)));

  assert_zero_thresh_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thresh_i == '0) |=> (tx_start_o == $past(manual_start_i)));

  assert_armed_fires_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && auto_en_i && met_i && !pkt_sel_i) |=> (tx_start_o && !armed_i));

  assert_early_met_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enq_i && auto_en_i && met_i && !pkt_sel_i) |=> tx_start_o);

  assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_en_i && !enq_i && !armed_i) |=> !tx_start_o);

  assert_cancel_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_sel_i || !auto_en_i) |=> !armed_i);
endmodule

bind etx_auto_start etx_auto_start_chk i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pkt_sel_i     (pkt_sel_i),
  .enq_i         (enq_i),
  .manual_start_i(manual_start_i),
  .thresh_i      (thresh_i),
  .tx_start_o    (tx_start_o),
  .cnt_i         (cnt_w),
  .auto_en_i     (auto_en_w),
  .met_i         (met_w),
  .armed_i       (armed_w)
);

// File: tb/test_etx_auto_start.sv
`timescale 1ns/1ps
module test_etx_auto_start;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] thresh = '0;
  logic       auto_tx = 1'b0, eten = 1'b0, rcv = 1'b0;
  logic       sel = 1'b0, wr = 1'b0, enq = 1'b0, man = 1'b0;
  logic [1:0] nbytes = '0;
  logic       tx_start;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string cur_req = "R11";

  typedef struct { logic exp; string req; } item_t;
  item_t sb_q[$];

  // reference state, built from the requirements
  int  m_cnt   = 0;
  bit  m_armed = 1'b0;

  always #5 clk = ~clk;

  etx_auto_start i_etx_auto_start (
    .clk_i(clk), .rst_ni(rst_n), .thresh_i(thresh), .auto_tx_i(auto_tx),
    .early_tx_en_i(eten), .rcv_sel_i(rcv), .pkt_sel_i(sel), .wr_valid_i(wr),
    .wr_bytes_i(nbytes), .enq_i(enq), .manual_start_i(man), .tx_start_o(tx_start)
  );

  // driver: apply inputs for one cycle, push expected output after the edge
  task automatic step(input bit s, input bit w, input int nb, input bit e, input bit m);
    bit en, met, fire;
    item_t it;
    sel = s; wr = w; nbytes = 2'(nb); enq = e; man = m;
    en   = auto_tx && eten && !rcv && (thresh != 0);
    met  = (m_cnt >= int'(thresh) * 16);
    fire = en && !s && met && (e || m_armed);
    it.exp = en ? fire : m;
    it.req = cur_req;
    m_armed = en && !s && !met && (e || m_armed);
    if (s)      m_cnt = 0;
    else if (w) m_cnt = (m_cnt + nb > 2047) ? 2047 : m_cnt + nb;
    @(posedge clk);
    sb_q.push_back(it);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  task automatic write_n(input int n, input int nb);
    for (int i = 0; i < n; i++) step(0, 1, nb, 0, 0);
  endtask

  task automatic auto_cfg(input int t);
    thresh = 8'(t); auto_tx = 1'b1; eten = 1'b1; rcv = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (tx_start !== it.exp) begin
        fails++;
        $display("FAIL %s: tx_start_o=%0b expected %0b at %0t", it.req, tx_start, it.exp, $time);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #2;
    // R11 reset
    @(negedge clk);
    checks++;
    if (tx_start !== 1'b0) begin
      fails++;
      $display("FAIL R11: tx_start_o=%0b expected 0", tx_start);
    end
    #3 rst_n = 1'b1;
    @(posedge clk); #1;
    cur_req = "R11"; idle(2);

    // R1 count starts at 0: 15 bytes short of 16, one more fires
    auto_cfg(1);
    cur_req = "R1";  write_n(5, 3); step(0, 0, 0, 1, 0); idle(2);
    cur_req = "R4";  step(0, 1, 1, 0, 0); idle(3);

    // R4 armed, then reach threshold with same-cycle write (R3)
    auto_cfg(2);
    cur_req = "R3";  step(1, 0, 0, 0, 0); write_n(10, 3); step(0, 1, 1, 1, 0);
    idle(2);
    cur_req = "R4";  step(0, 1, 1, 0, 0); idle(3);

    // R5 threshold met before enqueue
    cur_req = "R5";  step(1, 0, 0, 0, 0); write_n(16, 3); step(0, 0, 0, 1, 0);
    cur_req = "R6";  write_n(4, 3); idle(4);
    cur_req = "R5";  step(0, 1, 2, 1, 0); step(0, 0, 0, 1, 0); idle(3);

    // R7 manual ignored in auto mode
    cur_req = "R7";  step(0, 0, 0, 0, 1); step(0, 0, 0, 0, 1); idle(2);

    // R2/R7 each gate drops to manual
    cur_req = "R2";
    auto_tx = 1'b0; step(0, 0, 0, 1, 0); step(0, 0, 0, 0, 1); step(0, 0, 0, 1, 1); idle(2);
    auto_cfg(2); eten = 1'b0; step(0, 0, 0, 1, 0); step(0, 0, 0, 0, 1); idle(2);
    auto_cfg(2); rcv = 1'b1;  step(0, 0, 0, 1, 0); step(0, 0, 0, 0, 1); idle(2);
    cur_req = "R7";
    auto_tx = 1'b0; rcv = 1'b0; step(0, 0, 0, 0, 1); step(0, 0, 0, 0, 1); step(0, 0, 0, 0, 0);

    // R8 zero threshold
    cur_req = "R8";  auto_cfg(0); step(0, 0, 0, 1, 0); step(0, 0, 0, 0, 1); idle(2);

    // R9 cancel by select and by mode drop
    cur_req = "R9";
    auto_cfg(3); step(1, 0, 0, 0, 0); step(0, 0, 0, 1, 0); step(1, 0, 0, 0, 0);
    write_n(20, 3); idle(3);
    step(1, 0, 0, 0, 0); step(0, 0, 0, 1, 0); auto_tx = 1'b0; step(0, 0, 0, 0, 0);
    auto_tx = 1'b1; write_n(20, 3); idle(3);
    step(1, 0, 0, 0, 0); step(0, 0, 0, 1, 0); thresh = 8'd0; step(0, 0, 0, 0, 0);
    thresh = 8'd3; write_n(20, 3); idle(3);

    // R1 saturation with threshold 127 (2032)
    cur_req = "R1";
    auto_cfg(127); step(1, 0, 0, 0, 0); write_n(682, 3); write_n(2, 3);
    step(0, 0, 0, 1, 0); idle(3);

    // R10 threshold 128 never met
    cur_req = "R10";
    thresh = 8'd128; step(0, 0, 0, 1, 0); write_n(10, 3); idle(5);
    thresh = 8'd255; step(0, 0, 0, 1, 0); idle(5);

    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule